// File: doc/BRIEF.md
# SAR Conversion and Power-Down Controller

This block is the digital sequencer of a 14-bit successive-approximation converter. A falling edge on the active-low start input, seen while chip select is low, opens a conversion. The controller then walks a trial code down from the top bit to bit zero, one comparator decision per divided conversion-clock period. It copies the final code into an output latch, and only after that does it release the busy status. A separate enable tells the pad ring when the parallel result may drive the bus.

The controller also guards the analog front end. After each conversion an acquisition window must pass before the next start. After a power-down a wake-up window must pass as well. A start request that lands inside either window is remembered and flagged, and it launches as soon as the window closes. Pulling the shutdown input low while the block is idle parks it in a light (nap) or deep (sleep) power-down state. The level of chip select at that moment chooses which one.

Top module: `sar_conv_ctrl`

## Requirements
- R1: A conversion is accepted only on a clock where `conv_ni` is sampled low, was sampled high one clock earlier, and `cs_ni` is low. A falling edge while `cs_ni` is high has no effect. Lowering `cs_ni` while `conv_ni` is already low has no effect either.
- R2: On the clock after the start is accepted, the SAR holds only the top trial bit: `dac_code_o` equals 1 << (N_BITS-1), which is 0x2000 by default.
- R3: Every CLK_DIV clocks the current trial bit is decided. It stays 1 when `cmp_i` is 1 (input at or above the DAC value) and is cleared otherwise, and the next lower bit is then set as the new trial. Bits are decided from the top bit down to bit 0.
- R4: `busy_no_o` is low for exactly N_BITS*CLK_DIV+1 clocks per conversion, which is 57 by default.
- R5: The final code is in `data_o` one clock before `busy_no_o` rises. With an ideal comparator the code equals the analog input code.
- R6: Start edges that arrive during a conversion are dropped. They neither restart it nor queue another conversion.
- R7: `data_oe_o` is high exactly when both `rd_ni` and `cs_ni` are low.
- R8: `shdn_ni` low while idle enters nap if `cs_ni` is low and sleep if `cs_ni` is high. The mode shows on `nap_o` or `sleep_o` from the next clock. Start edges are ignored while powered down.
- R9: After `shdn_ni` returns high, a start is held off until WAKE_CYC clocks (from nap) or SLEEP_WAKE_CYC clocks (from sleep) have passed. A start made in that window begins on the (window+1)-th clock after release.
- R10: After `busy_no_o` rises it stays high for at least ACQ_CYC+1 clocks. A start made inside this window sets `start_held_o` and launches so that `busy_no_o` falls exactly ACQ_CYC+1 clocks after it rose.
- R11: After reset `busy_no_o` is high, `data_o` is zero, and `nap_o`, `sleep_o` and `start_held_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low; also picks the power-down mode |
| conv_ni | input | 1 | Conversion start, acts on its falling edge |
| rd_ni | input | 1 | Read strobe, active low |
| shdn_ni | input | 1 | Power-down request, active low |
| cmp_i | input | 1 | Comparator: 1 when input is at or above the DAC value |
| dac_code_o | output | N_BITS | Trial code driven to the capacitive DAC |
| data_o | output | N_BITS | Output latch contents |
| data_oe_o | output | 1 | Parallel bus drive enable; bus is high-impedance when low |
| busy_no_o | output | 1 | Low while a conversion is in progress |
| nap_o | output | 1 | Nap power-down state |
| sleep_o | output | 1 | Sleep power-down state |
| start_held_o | output | 1 | A start is waiting for an acquisition or wake-up window |

## Verification
The start-qualification check assumes that the start input is held low across exactly one rising edge per request and that chip select is steady around that edge. Every directed pulse in the bench is therefore driven on a falling clock edge and released on the next one. The conversion-length and acquisition-gap checks assume that the comparator bit is valid during the clock that ends each decision period. The bench derives it combinationally from the trial code and a held input value, so it settles well before the deciding edge. Shutdown is only changed while the block is idle and past its acquisition window.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_CONV, ST_LATCH} conv_st_e;
  typedef enum logic [1:0] {PWR_ON, PWR_NAP, PWR_SLEEP} pwr_st_e;
endpackage

// File: rtl/sar_bit_timer.sv
module sar_bit_timer #(
  parameter int CLK_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  generate
    if (CLK_DIV <= 1) begin : g_nodiv
      assign tick_o = run_i;
    end else begin : g_div
      localparam int CW = $clog2(CLK_DIV);
      localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)           cnt_q <= '0;
        else if (!run_i)       cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = run_i && (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/sar_approx.sv
module sar_approx #(
  parameter int N_BITS = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic              cmp_i,
  output logic [N_BITS-1:0] trial_o,
  output logic [N_BITS-1:0] next_o,
  output logic              last_o
);
  localparam logic [N_BITS-1:0] TOP = {1'b1, {(N_BITS-1){1'b0}}};

  logic [N_BITS-1:0] sar_q, ptr_q;

  // decide current bit, arm the next lower one
  assign next_o  = (sar_q & ~ptr_q) | (cmp_i ? ptr_q : '0) | (ptr_q >> 1);
  assign last_o  = ptr_q[0];
  assign trial_o = sar_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sar_q <= '0;
      ptr_q <= '0;
    end else if (load_i) begin
      sar_q <= TOP;
      ptr_q <= TOP;
    end else if (step_i && (ptr_q != '0)) begin
      sar_q <= next_o;
      ptr_q <= ptr_q >> 1;
    end
  end
endmodule

// File: rtl/sar_pwr_gate.sv
module sar_pwr_gate
  import sar_pkg::*;
#(
  parameter int ACQ_CYC        = 200,
  parameter int WAKE_CYC       = 200,
  parameter int SLEEP_WAKE_CYC = 400
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    idle_i,
  input  logic    conv_done_i,
  input  logic    shdn_ni,
  input  logic    cs_ni,
  output pwr_st_e pwr_o,
  output logic    open_o
);
  localparam int MAX_A = (ACQ_CYC > WAKE_CYC) ? ACQ_CYC : WAKE_CYC;
  localparam int MAX_C = (MAX_A > SLEEP_WAKE_CYC) ? MAX_A : SLEEP_WAKE_CYC;
  localparam int GW    = $clog2(MAX_C + 1);

  pwr_st_e       pwr_q;
  logic [GW-1:0] gate_q, wake_v;

  assign wake_v = (pwr_q == PWR_NAP) ? GW'(WAKE_CYC) : GW'(SLEEP_WAKE_CYC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwr_q  <= PWR_ON;
      gate_q <= '0;
    end else begin
      if (pwr_q == PWR_ON) begin
        if (idle_i && !shdn_ni) pwr_q <= cs_ni ? PWR_SLEEP : PWR_NAP;
        if (conv_done_i)        gate_q <= GW'(ACQ_CYC);
        else if (gate_q != '0)  gate_q <= gate_q - 1'b1;
      end else if (shdn_ni) begin
        pwr_q  <= PWR_ON;
        // never shorten a pending acquisition window
        gate_q <= (gate_q > wake_v) ? gate_q : wake_v;
      end else if (gate_q != '0) begin
        gate_q <= gate_q - 1'b1;
      end
    end
  end

  assign pwr_o  = pwr_q;
  assign open_o = (pwr_q == PWR_ON) && (gate_q == '0);
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_pkg::*;
#(
  parameter int N_BITS         = 14,
  parameter int CLK_DIV        = 4,
  parameter int ACQ_CYC        = 200,
  parameter int WAKE_CYC       = 200,
  parameter int SLEEP_WAKE_CYC = 400
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              conv_ni,
  input  logic              rd_ni,
  input  logic              shdn_ni,
  input  logic              cmp_i,
  output logic [N_BITS-1:0] dac_code_o,
  output logic [N_BITS-1:0] data_o,
  output logic              data_oe_o,
  output logic              busy_no_o,
  output logic              nap_o,
  output logic              sleep_o,
  output logic              start_held_o
);
  conv_st_e          st_q, st_d;
  pwr_st_e           pwr;
  logic              conv_q, pend_q;
  logic [N_BITS-1:0] data_q, trial, next_code;
  logic              tick, last, gate_open;
  logic              fall, idle, pd_req, launch, done;

  assign fall   = conv_q && !conv_ni && !cs_ni;
  assign idle   = (st_q == ST_IDLE);
  assign pd_req = (pwr != PWR_ON) || !shdn_ni;
  assign launch = idle && gate_open && !pd_req && (fall || pend_q);
  assign done   = (st_q == ST_CONV) && tick && last;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (launch) st_d = ST_CONV;
      ST_CONV:  if (done)   st_d = ST_LATCH;
      ST_LATCH:             st_d = ST_IDLE;
      default:              st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      conv_q <= 1'b1;
      pend_q <= 1'b0;
      data_q <= '0;
    end else begin
      st_q   <= st_d;
      conv_q <= conv_ni;
      if (launch)            pend_q <= 1'b0;
      else if (pd_req)       pend_q <= 1'b0;
      else if (idle && fall) pend_q <= 1'b1;
      if (done) data_q <= next_code;
    end
  end

  sar_bit_timer #(.CLK_DIV(CLK_DIV)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (st_q == ST_CONV),
    .tick_o(tick)
  );

  sar_approx #(.N_BITS(N_BITS)) u_sar (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (launch),
    .step_i (tick && (st_q == ST_CONV)),
    .cmp_i  (cmp_i),
    .trial_o(trial),
    .next_o (next_code),
    .last_o (last)
  );

  sar_pwr_gate #(
    .ACQ_CYC       (ACQ_CYC),
    .WAKE_CYC      (WAKE_CYC),
    .SLEEP_WAKE_CYC(SLEEP_WAKE_CYC)
  ) u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .idle_i     (idle),
    .conv_done_i(st_q == ST_LATCH),
    .shdn_ni    (shdn_ni),
    .cs_ni      (cs_ni),
    .pwr_o      (pwr),
    .open_o     (gate_open)
  );

  assign dac_code_o   = trial;
  assign data_o       = data_q;
  assign data_oe_o    = !rd_ni && !cs_ni;
  assign busy_no_o    = idle;
  assign nap_o        = (pwr == PWR_NAP);
  assign sleep_o      = (pwr == PWR_SLEEP);
  assign start_held_o = pend_q;
endmodule

// File: rtl/sar_conv_ctrl_chk.sv
module sar_conv_ctrl_chk #(
  parameter int N_BITS  = 14,
  parameter int CLK_DIV = 4,
  parameter int ACQ_CYC = 200
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              conv_ni,
  input logic              busy_no_o,
  input logic [N_BITS-1:0] dac_code_o,
  input logic [N_BITS-1:0] data_o,
  input logic              nap_o,
  input logic              sleep_o,
  input logic              start_held_o
);
  localparam int CONV_CYC = N_BITS * CLK_DIV + 1;
  localparam int LW       = $clog2(CONV_CYC + 2);
  localparam int GAP      = ACQ_CYC + 1;
  localparam int GW       = $clog2(GAP + 2);
  localparam logic [N_BITS-1:0] TOP = {1'b1, {(N_BITS-1){1'b0}}};

  logic [LW-1:0] low_cnt;
  logic [GW-1:0] gap_cnt;
  logic [1:0]    age;
  logic          age_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt <= '0;
      gap_cnt <= GW'(GAP);
      age     <= '0;
    end else begin
      if (age != 2'd3) age <= age + 1'b1;
      if (busy_no_o) low_cnt <= '0;
      else if (low_cnt != LW'(CONV_CYC + 1)) low_cnt <= low_cnt + 1'b1;
      if (!busy_no_o) gap_cnt <= '0;
      else if (gap_cnt != GW'(GAP)) gap_cnt <= gap_cnt + 1'b1;
    end
  end
  assign age_ok = (age == 2'd3);

  AST_QUAL_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_ok && $fell(busy_no_o)) |->
      ($past(start_held_o) || (!$past(cs_ni) && !$past(conv_ni) && $past(conv_ni, 2)))); // R1
  AST_MSB_TRIAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_no_o) |-> (dac_code_o == TOP)); // R2
  AST_CONV_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_no_o) |-> (low_cnt == LW'(CONV_CYC))); // R4
  AST_DATA_BEFORE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_no_o) |-> $stable(data_o)); // R5
  AST_IDLE_IN_PD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nap_o || sleep_o) |-> busy_no_o); // R8
  AST_PD_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(nap_o && sleep_o)); // R8
  AST_ACQ_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_no_o) |-> (gap_cnt == GW'(GAP))); // R10
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(
  .N_BITS (N_BITS),
  .CLK_DIV(CLK_DIV),
  .ACQ_CYC(ACQ_CYC)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_ni       (cs_ni),
  .conv_ni     (conv_ni),
  .busy_no_o   (busy_no_o),
  .dac_code_o  (dac_code_o),
  .data_o      (data_o),
  .nap_o       (nap_o),
  .sleep_o     (sleep_o),
  .start_held_o(start_held_o)
);

// File: tb/sar_conv_ctrl_test.sv
module sar_conv_ctrl_test;
  localparam int N   = 14;
  localparam int DIV = 4;
  localparam int ACQ = 200;
  localparam int WK  = 200;
  localparam int SWK = 400;
  localparam int CONV_LEN = N * DIV + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, conv_n = 1'b1, rd_n = 1'b1, shdn_n = 1'b1;
  logic [N-1:0] vin = '0;
  logic [N-1:0] dac, dout;
  logic oe, busy_n, nap, slp, held, cmp;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign cmp = (vin >= dac);

  sar_conv_ctrl #(.N_BITS(N), .CLK_DIV(DIV), .ACQ_CYC(ACQ), .WAKE_CYC(WK),
                  .SLEEP_WAKE_CYC(SWK)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .conv_ni(conv_n), .rd_ni(rd_n),
    .shdn_ni(shdn_n), .cmp_i(cmp), .dac_code_o(dac), .data_o(dout),
    .data_oe_o(oe), .busy_no_o(busy_n), .nap_o(nap), .sleep_o(slp),
    .start_held_o(held));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  // pulse start, return busy-low length; ends on first sample with busy high
  task automatic run_conv(output int len);
    cs_n = 1'b0; conv_n = 1'b0;
    tick();
    conv_n = 1'b1;
    len = 0;
    while (!busy_n && len < 1000) begin len++; tick(); end
  endtask

  task automatic t_reset;
    check(busy_n == 1'b1, "R11 busy", busy_n, 1);
    check(dout == '0, "R11 data", dout, 0);
    check(!nap && !slp && !held, "R11 flags", {nap, slp, held}, 0);
  endtask

  task automatic t_convert(input logic [N-1:0] v);
    int len;
    vin = v;
    run_conv(len);
    check(len == CONV_LEN, "R4 busy length", len, CONV_LEN);
    check(dout == v, "R5 result", dout, v);
    tick(ACQ + 3);
  endtask

  task automatic t_msb_first;
    vin = 14'h3000;
    cs_n = 1'b0; conv_n = 1'b0;
    tick();
    conv_n = 1'b1;
    check(dac == 14'h2000, "R2 first trial", dac, 14'h2000);
    tick(DIV);
    check(dac == 14'h3000, "R3 top bit kept", dac, 14'h3000);
    tick(DIV);
    check(dac == 14'h3800, "R3 bit12 kept", dac, 14'h3800);
    tick(DIV);
    check(dac == 14'h3400, "R3 bit11 cleared", dac, 14'h3400);
    while (!busy_n) tick();
    check(dout == 14'h3000, "R5 result", dout, 14'h3000);
    tick(ACQ + 3);
    vin = 14'h0800;
    cs_n = 1'b0; conv_n = 1'b0;
    tick();
    conv_n = 1'b1;
    tick(DIV);
    check(dac == 14'h1000, "R3 top bit cleared", dac, 14'h1000);
    while (!busy_n) tick();
    tick(ACQ + 3);
  endtask

  task automatic t_cs_gate;
    logic [N-1:0] prev;
    bit seen_low;
    prev = dout;
    seen_low = 1'b0;
    vin = 14'h0123;
    cs_n = 1'b1; conv_n = 1'b0;
    tick();
    cs_n = 1'b0;
    for (int i = 0; i < 6; i++) begin tick(); if (!busy_n) seen_low = 1'b1; end
    conv_n = 1'b1;
    tick(2);
    check(!seen_low, "R1 gated start", seen_low, 0);
    check(dout == prev, "R1 data kept", dout, prev);
    check(!held, "R1 nothing held", held, 0);
  endtask

  task automatic t_no_restart;
    int len;
    bit seen_low;
    vin = 14'd1234;
    cs_n = 1'b0; conv_n = 1'b0;
    tick();
    conv_n = 1'b1;
    len = 0;
    while (!busy_n && len < 1000) begin
      len++;
      conv_n = (len == 20) ? 1'b0 : 1'b1;
      tick();
    end
    conv_n = 1'b1;
    check(len == CONV_LEN, "R6 length unchanged", len, CONV_LEN);
    check(dout == 14'd1234, "R6 result", dout, 1234);
    seen_low = 1'b0;
    for (int i = 0; i < ACQ + 10; i++) begin
      if (!busy_n || held) seen_low = 1'b1;
      tick();
    end
    check(!seen_low, "R6 not queued", seen_low, 0);
  endtask

  task automatic t_read_enable;
    cs_n = 1'b1; rd_n = 1'b0; #1;
    check(oe == 1'b0, "R7 cs high", oe, 0);
    cs_n = 1'b0; rd_n = 1'b1; #1;
    check(oe == 1'b0, "R7 rd high", oe, 0);
    rd_n = 1'b0; #1;
    check(oe == 1'b1, "R7 both low", oe, 1);
    rd_n = 1'b1;
    tick();
  endtask

  task automatic t_holdoff;
    int len;
    vin = 14'h1ABC;
    run_conv(len);
    vin = 14'h0F0F;
    conv_n = 1'b0;
    tick();
    conv_n = 1'b1;
    check(held == 1'b1, "R10 held flag", held, 1);
    tick(ACQ - 1);
    check(busy_n == 1'b1, "R10 window closed", busy_n, 1);
    tick();
    check(busy_n == 1'b0, "R10 held start launched", busy_n, 0);
    check(held == 1'b0, "R10 flag cleared", held, 0);
    while (!busy_n) tick();
    check(dout == 14'h0F0F, "R5 held result", dout, 14'h0F0F);
    tick(ACQ + 3);
  endtask

  task automatic t_pdown(input bit deep);
    int win;
    bit seen_low;
    win = deep ? SWK : WK;
    cs_n = deep; shdn_n = 1'b0;
    tick();
    cs_n = 1'b0;
    check(nap == !deep && slp == deep, deep ? "R8 sleep entry" : "R8 nap entry",
          {nap, slp}, deep ? 1 : 2);
    seen_low = 1'b0;
    conv_n = 1'b0;
    tick();
    conv_n = 1'b1;
    for (int i = 0; i < 4; i++) begin if (!busy_n || held) seen_low = 1'b1; tick(); end
    check(!seen_low, "R8 start ignored", seen_low, 0);
    vin = deep ? 14'h2222 : 14'h1111;
    shdn_n = 1'b1;
    tick();
    check(!nap && !slp, "R9 awake", {nap, slp}, 0);
    conv_n = 1'b0;
    tick();
    conv_n = 1'b1;
    check(held == 1'b1, "R9 held in wake window", held, 1);
    tick(win - 1);
    check(busy_n == 1'b1, "R9 wake window", busy_n, 1);
    tick();
    check(busy_n == 1'b0, "R9 start after wake", busy_n, 0);
    while (!busy_n) tick();
    check(dout == vin, "R9 result", dout, vin);
    tick(ACQ + 3);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(3);
    t_reset();
    t_convert(14'h0000);
    t_convert(14'h3FFF);
    t_convert(14'h2AAA);
    t_convert(14'h1555);
    t_convert(14'h2000);
    t_convert(14'h1FFF);
    t_msb_first();
    t_cs_gate();
    t_no_restart();
    t_read_enable();
    t_holdoff();
    t_pdown(1'b0);
    t_pdown(1'b1);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end
endmodule